// File: doc/BRIEF.md
# Decode-Stage Hazard and Branch Controller

This block makes the control decisions for the decode stage of a five-stage integer pipeline (fetch, decode, execute, memory, write-back). Each cycle it receives the class of the instruction sitting in decode, that instruction's source and destination register indices, and a vector of per-register pending flags from the register scoreboard. From these it decides whether decode and fetch must hold, whether a bubble goes into the fetch/decode register in place of a fresh fetch, whether the decode/execute register must be cleared, and whether the instruction's destination must be marked pending.

Two runtime controls shape the decisions. A forwarding enable relaxes the ordinary data-hazard checks. A two-bit branch policy picks how a branch in decode is handled: the freeze and predict-taken policies place a bubble behind the branch, while the predict-not-taken and delayed-slot policies let the next sequential instruction be fetched. A branch always waits in decode until its source register is no longer pending. Every output is a plain level control, valid in the cycle it is produced; branch target computation and the datapath stay outside the block.

Top module: `pipe_hazard_ctl`

## Requirements
- R1: With forwarding disabled, an instruction of class 0 (register-register) in decode asserts stall when the pending flag of its rs or its rt register is set.
- R2: With forwarding disabled, class 1 (immediate, including loads) stalls only on a pending rs; class 2 (store) stalls on a pending rs or a pending rt.
- R3: With forwarding enabled, classes 0, 1 and 2 never stall, whatever the pending flags.
- R4: Class 3 (branch on zero) and class 4 (register jump) stall whenever the rs pending flag is set, with forwarding on or off; rt is not examined for them.
- R5: Register 0 never causes a hazard and is never marked pending.
- R6: A decode instruction that advances (no stall) requests a mark of its destination: rd for class 0, rt for class 1. Classes 2, 3 and 4 never request a mark, and no mark is requested while stalled.
- R7: While stall is high, fetch_en and pc_inc are low (fetch and decode hold) and idex_clr is high (a bubble enters execute).
- R8: Under policy 0 (freeze) or 1 (predict-taken), a branch or register jump advancing out of decode raises bubble and lowers fetch_en and pc_inc in that cycle; under policy 2 (predict-not-taken) or 3 (delayed slot) it raises no bubble and fetch_en and pc_inc stay high.
- R9: When a bubble request and a stall coincide, stall wins and bubble stays low; the bubble is issued in the first later cycle without a stall, even if the policy has changed by then.
- R10: In the cycle after bubble is high, decode holds the bubble: idex_clr is high and the decode inputs are ignored, so stall, mark_en and bubble stay low.
- R11: After reset, with no valid decode instruction, stall, bubble, idex_clr and mark_en are low and fetch_en and pc_inc are high.
- R12: Class codes 5 to 7 neither stall nor request a mark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| id_valid | input | 1 | Decode stage holds an instruction |
| id_cls | input | 3 | Instruction class: 0 reg-reg, 1 immediate, 2 store, 3 branch on zero, 4 register jump |
| id_rs | input | IDX_W | Source (base) register index |
| id_rt | input | IDX_W | Second source, or destination for class 1 |
| id_rd | input | IDX_W | Destination for class 0 |
| reg_pend | input | NREG | Scoreboard pending flag per register |
| fwd_en | input | 1 | Forwarding enabled |
| br_policy | input | 2 | Branch policy: 0 freeze, 1 predict-taken, 2 predict-not-taken, 3 delayed slot |
| stall | output | 1 | Hold decode and fetch this cycle |
| bubble | output | 1 | Load a bubble into the fetch/decode register instead of fetching |
| fetch_en | output | 1 | Latch the fetched instruction and next PC |
| pc_inc | output | 1 | Advance the PC by 4 |
| idex_clr | output | 1 | Clear the decode/execute register |
| mark_en | output | 1 | Mark a destination register pending |
| mark_idx | output | IDX_W | Register index to mark |

## Verification
The block keeps only two bits of state: a deferred-bubble flag and a flag saying decode holds a bubble. A wrong deferred flag shows at the ports as a missing or doubled bubble in the first unstalled cycle after a stalled branch under the freeze or predict-taken policy. A wrong bubble-in-decode flag shows one cycle after a bubble, as idex_clr low or as a stall or mark taken from decode fields that should be ignored. Every other output is a same-cycle function of the inputs, so a fault there is visible in the very cycle the offending input pattern is applied.

// File: rtl/hz_pkg.sv
package hz_pkg;

  typedef enum logic [2:0] {
    CLS_RR    = 3'd0,
    CLS_IMM   = 3'd1,
    CLS_STORE = 3'd2,
    CLS_BRZ   = 3'd3,
    CLS_JREG  = 3'd4
  } iclass_e;

  typedef enum logic [1:0] {
    POL_FREEZE = 2'd0,
    POL_TAKEN  = 2'd1,
    POL_NTAKEN = 2'd2,
    POL_DELAY  = 2'd3
  } brpol_e;

  function automatic logic is_branch(input logic [2:0] cls);
    return (cls == CLS_BRZ) || (cls == CLS_JREG);
  endfunction

  function automatic logic policy_bubbles(input logic [1:0] pol);
    return (pol == POL_FREEZE) || (pol == POL_TAKEN);
  endfunction

endpackage

// File: rtl/hz_detect.sv
module hz_detect
  import hz_pkg::*;
#(
  parameter int NREG  = 32,
  parameter int IDX_W = 5,
  parameter bit ZERO_REG_FIXED = 1'b1
) (
  input  logic             valid,
  input  logic [2:0]       cls,
  input  logic [IDX_W-1:0] rs,
  input  logic [IDX_W-1:0] rt,
  input  logic [NREG-1:0]  pend,
  input  logic             fwd_en,
  output logic             hazard
);

  logic [NREG-1:0] pend_eff;
  logic            rs_busy, rt_busy;

  generate
    if (ZERO_REG_FIXED) begin : g_zero_masked
      always_comb begin
        pend_eff    = pend;
        pend_eff[0] = 1'b0;
      end
    end else begin : g_zero_live
      assign pend_eff = pend;
    end
  endgenerate

  assign rs_busy = pend_eff[rs];
  assign rt_busy = pend_eff[rt];

  always_comb begin
    hazard = 1'b0;
    if (valid) begin
      unique case (cls)
        CLS_RR:    hazard = !fwd_en && (rs_busy || rt_busy);
        CLS_IMM:   hazard = !fwd_en && rs_busy;
        CLS_STORE: hazard = !fwd_en && (rs_busy || rt_busy);
        CLS_BRZ,
        CLS_JREG:  hazard = rs_busy;
        default:   hazard = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/hz_branch_seq.sv
module hz_branch_seq
  import hz_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       valid,
  input  logic [2:0] cls,
  input  logic [1:0] policy,
  input  logic       stall,
  output logic       bubble,
  output logic       bub_in_id
);

  logic want_bub;
  logic defer_q;
  logic bub_any;

  assign want_bub = valid && is_branch(cls) && policy_bubbles(policy);
  assign bub_any  = want_bub || defer_q;
  assign bubble   = bub_any && !stall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      defer_q   <= 1'b0;
      bub_in_id <= 1'b0;
    end else begin
      defer_q   <= bub_any && stall;
      bub_in_id <= bubble;
    end
  end

endmodule

// File: rtl/hz_mark.sv
module hz_mark
  import hz_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             valid,
  input  logic [2:0]       cls,
  input  logic [IDX_W-1:0] rd,
  input  logic [IDX_W-1:0] rt,
  input  logic             stall,
  output logic             mark_en,
  output logic [IDX_W-1:0] mark_idx
);

  logic writes;

  always_comb begin
    writes   = 1'b0;
    mark_idx = '0;
    unique case (cls)
      CLS_RR:  begin writes = 1'b1; mark_idx = rd; end
      CLS_IMM: begin writes = 1'b1; mark_idx = rt; end
      default: begin writes = 1'b0; mark_idx = '0; end
    endcase
  end

  assign mark_en = valid && writes && !stall && (mark_idx != '0);

endmodule

// File: rtl/pipe_hazard_ctl.sv
module pipe_hazard_ctl
  import hz_pkg::*;
#(
  parameter  int NREG  = 32,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             id_valid,
  input  logic [2:0]       id_cls,
  input  logic [IDX_W-1:0] id_rs,
  input  logic [IDX_W-1:0] id_rt,
  input  logic [IDX_W-1:0] id_rd,
  input  logic [NREG-1:0]  reg_pend,
  input  logic             fwd_en,
  input  logic [1:0]       br_policy,
  output logic             stall,
  output logic             bubble,
  output logic             fetch_en,
  output logic             pc_inc,
  output logic             idex_clr,
  output logic             mark_en,
  output logic [IDX_W-1:0] mark_idx
);

  logic bub_in_id;
  logic live;

  // a bubble sitting in decode masks whatever the decode fields say
  assign live = id_valid && !bub_in_id;

  hz_detect #(.NREG(NREG), .IDX_W(IDX_W), .ZERO_REG_FIXED(1'b1)) u_detect (
    .valid  (live),
    .cls    (id_cls),
    .rs     (id_rs),
    .rt     (id_rt),
    .pend   (reg_pend),
    .fwd_en (fwd_en),
    .hazard (stall)
  );

  hz_branch_seq u_branch (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid     (live),
    .cls       (id_cls),
    .policy    (br_policy),
    .stall     (stall),
    .bubble    (bubble),
    .bub_in_id (bub_in_id)
  );

  hz_mark #(.IDX_W(IDX_W)) u_mark (
    .valid    (live),
    .cls      (id_cls),
    .rd       (id_rd),
    .rt       (id_rt),
    .stall    (stall),
    .mark_en  (mark_en),
    .mark_idx (mark_idx)
  );

  assign fetch_en = !stall && !bubble;
  assign pc_inc   = fetch_en;
  assign idex_clr = stall || bub_in_id;

endmodule

// File: rtl/pipe_hazard_ctl_chk.sv
module pipe_hazard_ctl_chk #(
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             id_valid,
  input logic [2:0]       id_cls,
  input logic             fwd_en,
  input logic             stall,
  input logic             bubble,
  input logic             fetch_en,
  input logic             pc_inc,
  input logic             idex_clr,
  input logic             mark_en,
  input logic [IDX_W-1:0] mark_idx
);

  AST_STALL_HOLDS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (!fetch_en && !pc_inc)); // R7

  AST_STALL_CLEARS_EX: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> idex_clr); // R7

  AST_BUBBLE_LOSES_TO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    bubble |-> (!stall && !fetch_en)); // R9

  AST_BUBBLE_THEN_IDLE_ID: assert property (@(posedge clk) disable iff (!rst_n)
    bubble |=> (idex_clr && !stall && !mark_en && !bubble)); // R10

  AST_NO_MARK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    mark_en |-> (mark_idx != '0)); // R5

  AST_FWD_NO_DATA_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_en && id_valid && (id_cls <= 3'd2)) |-> !stall); // R3

  AST_MARK_NOT_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    mark_en |-> !stall); // R6

endmodule

bind pipe_hazard_ctl pipe_hazard_ctl_chk #(.IDX_W(IDX_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .id_valid (id_valid),
  .id_cls   (id_cls),
  .fwd_en   (fwd_en),
  .stall    (stall),
  .bubble   (bubble),
  .fetch_en (fetch_en),
  .pc_inc   (pc_inc),
  .idex_clr (idex_clr),
  .mark_en  (mark_en),
  .mark_idx (mark_idx)
);

// File: tb/tb_pipe_hazard_ctl.sv
module tb_pipe_hazard_ctl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        id_valid = 1'b0;
  logic [2:0]  id_cls = 3'd0;
  logic [4:0]  id_rs = 5'd0, id_rt = 5'd0, id_rd = 5'd0;
  logic [31:0] reg_pend = 32'd0;
  logic        fwd_en = 1'b0;
  logic [1:0]  br_policy = 2'd0;
  logic        stall, bubble, fetch_en, pc_inc, idex_clr, mark_en;
  logic [4:0]  mark_idx;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int seed  = 12345;

  // reference state
  bit defer_m = 0;
  bit inid_m  = 0;

  always #10 clk = ~clk;

  pipe_hazard_ctl #(.NREG(32)) dut (
    .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_cls(id_cls),
    .id_rs(id_rs), .id_rt(id_rt), .id_rd(id_rd), .reg_pend(reg_pend),
    .fwd_en(fwd_en), .br_policy(br_policy), .stall(stall), .bubble(bubble),
    .fetch_en(fetch_en), .pc_inc(pc_inc), .idex_clr(idex_clr),
    .mark_en(mark_en), .mark_idx(mark_idx)
  );

  always @(posedge clk) cyc++;

  initial begin : watchdog
    wait (cyc > 100000);
    bad++; total++;
    $display("FAIL watchdog expired: actual=%0d expected<100000", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s cyc=%0d actual=%0d expected=%0d", tag, what, cyc, act, exp);
    end
  endtask

  function automatic int rnd();
    seed = seed * 1103515245 + 12345;
    return (seed >>> 8) & 32'h00ff_ffff;
  endfunction

  // one cycle: drive, compare with the model, advance the model
  task automatic step(input string tag, input bit v, input int c, input int s,
                      input int t, input int d, input logic [31:0] p,
                      input bit f, input int pol);
    bit live, hz, want, eb, em;
    int ei;
    logic [31:0] pe;
    @(negedge clk);
    id_valid = v; id_cls = c[2:0]; id_rs = s[4:0]; id_rt = t[4:0]; id_rd = d[4:0];
    reg_pend = p; fwd_en = f; br_policy = pol[1:0];
    #1;
    live = v && !inid_m;
    pe = p; pe[0] = 1'b0;
    hz = 0;
    if (live) begin
      if (c == 0)      hz = !f && (pe[s] || pe[t]);
      else if (c == 1) hz = !f && pe[s];
      else if (c == 2) hz = !f && (pe[s] || pe[t]);
      else if (c == 3 || c == 4) hz = pe[s];
    end
    want = live && (c == 3 || c == 4) && (pol < 2);
    eb = (want || defer_m) && !hz;
    ei = (c == 0) ? d : t;
    em = live && !hz && (c == 0 || c == 1) && (ei != 0);
    chk(tag, "stall", stall, hz);
    chk(tag, "bubble", bubble, eb);
    chk(tag, "fetch_en", fetch_en, !hz && !eb);
    chk(tag, "pc_inc", pc_inc, !hz && !eb);
    chk(tag, "idex_clr", idex_clr, hz || inid_m);
    chk(tag, "mark_en", mark_en, em);
    if (em) chk(tag, "mark_idx", mark_idx, ei);
    @(posedge clk);
    defer_m = (want || defer_m) && hz;
    inid_m  = eb;
  endtask

  function automatic logic [31:0] bit1(input int i);
    return 32'd1 << i;
  endfunction

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R11 reset state
    chk("R11", "stall", stall, 0);
    chk("R11", "bubble", bubble, 0);
    chk("R11", "idex_clr", idex_clr, 0);
    chk("R11", "mark_en", mark_en, 0);
    chk("R11", "fetch_en", fetch_en, 1);
    chk("R11", "pc_inc", pc_inc, 1);
    step("R11", 0, 0, 0, 0, 0, 32'hffff_ffff, 0, 0);

    // R1 reg-reg, forwarding off
    step("R1", 1, 0, 3, 4, 5, bit1(3), 0, 2);
    step("R1", 1, 0, 3, 4, 5, bit1(4), 0, 2);
    step("R1", 1, 0, 3, 4, 5, bit1(5), 0, 2);
    // R2 immediate vs store
    step("R2", 1, 1, 6, 7, 0, bit1(7), 0, 2);
    step("R2", 1, 1, 6, 7, 0, bit1(6), 0, 2);
    step("R2", 1, 2, 6, 7, 0, bit1(7), 0, 2);
    step("R2", 1, 2, 6, 7, 0, 32'd0, 0, 2);
    // R3 forwarding on
    step("R3", 1, 0, 3, 4, 5, 32'hffff_ffff, 1, 2);
    step("R3", 1, 2, 3, 4, 5, 32'hffff_ffff, 1, 2);
    // R4 branch ignores forwarding and rt
    step("R4", 1, 3, 8, 9, 0, bit1(8), 1, 2);
    step("R4", 1, 4, 8, 9, 0, bit1(9), 1, 2);
    // R5 register zero
    step("R5", 1, 0, 0, 0, 0, 32'h0000_0001, 0, 2);
    step("R5", 1, 1, 2, 0, 0, 32'd0, 0, 2);
    // R6 marks
    step("R6", 1, 0, 1, 2, 17, 32'd0, 0, 2);
    step("R6", 1, 1, 1, 22, 9, 32'd0, 0, 2);
    step("R6", 1, 2, 1, 22, 9, 32'd0, 0, 2);
    // R7 stall holds fetch
    step("R7", 1, 0, 3, 4, 5, bit1(4), 0, 0);
    // R8 policies
    for (int pol = 0; pol < 4; pol++) begin
      step("R8", 1, 3, 1, 0, 0, 32'd0, 0, pol);
      step("R10", 1, 0, 3, 4, 5, bit1(3), 0, pol);  // ignored if bubble in decode
      step("R8", 0, 0, 0, 0, 0, 32'd0, 0, pol);
    end
    // R9 stall + bubble request, then policy changed before release
    step("R9", 1, 3, 8, 0, 0, bit1(8), 0, 1);
    step("R9", 1, 3, 8, 0, 0, bit1(8), 0, 1);
    step("R9", 1, 0, 1, 2, 3, 32'd0, 0, 3);
    step("R10", 1, 1, 1, 2, 3, 32'd0, 0, 3);
    step("R9", 0, 0, 0, 0, 0, 32'd0, 0, 3);
    // R12 unused class codes
    for (int c = 5; c < 8; c++)
      step("R12", 1, c, 3, 4, 5, 32'hffff_ffff, 0, 0);

    // mixed pattern run
    for (int i = 0; i < 3000; i++) begin
      int c, pol;
      logic [31:0] p;
      c   = rnd() % 8;
      pol = rnd() % 4;
      p   = rnd() & rnd() & rnd();
      p   = {p[23:0], p[31:24]} ^ (rnd() << 8);
      p   = p & rnd() & rnd();
      step("RND", (rnd() % 8) != 0, c, rnd() % 32, rnd() % 32, rnd() % 32,
           p, (rnd() % 3) == 0, pol);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule